// File: doc/BRIEF.md
# Pipeline Stage Hotspot Profiler

This block watches eight per-stage activity flags coming out of a graphics pipeline and reports which stage was the bottleneck. Time is cut into measurement intervals of a programmable number of clock cycles. At the end of each interval one stage is credited: the one whose activity flag was high on the most cycles of that interval. Its 16-bit counter goes up by one. After a measurement, the eight counters therefore add up to the number of intervals that were completed.

Software first writes a configuration word. The low half holds the number of intervals to run, and the high half holds the interval length minus one. Software then pulses the start input. A measurement with a nonzero interval count stops by itself. With an interval count of zero, the measurement runs until software reads the first result word. Software collects the results by popping four 32-bit words, and each word carries two counters.

The controller is a four-state machine. IDLE is the state after reset. RUN is the measuring state. SNAP is a single cycle that copies the live counters into the result store. DONE holds the results. The transitions are:

- IDLE to RUN, on start.
- RUN to SNAP, when the last interval of a bounded measurement is credited.
- RUN to DONE, on the first read during an unbounded measurement.
- SNAP to DONE, unconditionally.
- DONE to RUN, on a new start.
- Any state to RUN, on start. Start always restarts the measurement.

Top module: `stage_profiler`

## Requirements
- R1: A one-cycle pulse on `start` clears all eight counters, the interval timer and the result pointer. `busy` is high from the following cycle onward.
- R2: A write on `cfg_wr` stores `cfg_data`. Bits 15:0 hold the interval count. Bits 31:16 hold L, and each interval then lasts L+1 clock cycles.
- R3: Each completed interval increments exactly one stage counter. Between interval ends, no counter changes.
- R4: The credited stage is the one whose `stage_busy` bit was high on the most cycles of the interval. On a tie, the lowest stage index wins.
- R5: When the interval lasts fewer than 3 cycles (L of 0 or 1), stage 0 is always credited.
- R6: With a nonzero interval count N, measurement stops after exactly N intervals and `busy` falls. The results then hold counters that sum to N.
- R7: With an interval count of 0, measurement runs until the first `rd_en`. That read returns the live counter values as word 0 and stops the measurement, so `busy` falls.
- R8: If the total number of credited intervals would pass 0xFFFF, all counters and the total wrap to zero.
- R9: Each `rd_en` pulse gives a word on `rd_data` with `rd_valid` high one cycle later. Word k carries stage 2k in bits 15:0 and stage 2k+1 in bits 31:16. Successive reads return words 0, 1, 2, 3 and then word 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 32 | Interval count [15:0], interval length minus one [31:16] |
| start | input | 1 | Start (or restart) a measurement |
| stage_busy | input | 8 | Per-stage activity flags |
| rd_en | input | 1 | Pop one result word |
| rd_valid | output | 1 | Result word valid, one cycle after `rd_en` |
| rd_data | output | 32 | Result word, two packed counters |
| busy | output | 1 | Measurement in progress |

## Verification
The bench targets stage selection in several ways:
- Ties between two stages, which catch a design that keeps the highest index on a tie.
- A stage busy on every cycle against a stage busy on every other cycle, which catches a design that credits by bit position instead of by count.
- Interval lengths of two and three cycles, which catch a design that misplaces the short-interval threshold.

It also runs an unbounded measurement for more than 65536 single-cycle intervals. A design that saturates its counters, or that never wraps them, reports a large value there instead of a small one. A fifth read after four must return word 0. A pointer that does not wrap, or one that is not reset on completion, returns the wrong word.

// File: rtl/stage_profiler_pkg.sv
package stage_profiler_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SNAP = 2'd2,
        ST_DONE = 2'd3
    } prof_state_e;

endpackage

// File: rtl/prof_interval_timer.sv
module prof_interval_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [LEN_W-1:0] len_m1,
    output logic             last_cycle
);
    logic [LEN_W-1:0] tick_q;

    assign last_cycle = run && (tick_q == len_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (clear) begin
            tick_q <= '0;
        end else if (run) begin
            tick_q <= last_cycle ? '0 : tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/prof_stage_select.sv
module prof_stage_select #(
    parameter int NUM_STAGES = 8,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN_M1 = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          run,
    input  logic                          last_cycle,
    input  logic [LEN_W-1:0]              len_m1,
    input  logic [NUM_STAGES-1:0]         stage_busy,
    output logic                          credit_valid,
    output logic [$clog2(NUM_STAGES)-1:0] credit_idx
);
    localparam int TALLY_W = LEN_W + 1;
    localparam int IDX_W   = $clog2(NUM_STAGES);

    logic [NUM_STAGES-1:0][TALLY_W-1:0] tally_q;
    logic [NUM_STAGES-1:0][TALLY_W-1:0] tally_nx;
    logic [IDX_W-1:0]                   best_idx;
    logic [TALLY_W-1:0]                 best_val;

    // Tallies including the current cycle's activity.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_tally
        assign tally_nx[g] = tally_q[g] + TALLY_W'(stage_busy[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tally_q[g] <= '0;
            end else if (clear || last_cycle) begin
                tally_q[g] <= '0;
            end else if (run) begin
                tally_q[g] <= tally_nx[g];
            end
        end
    end

    // Strict comparison keeps the lowest index on a tie.
    always_comb begin
        best_idx = '0;
        best_val = tally_nx[0];
        for (int i = 1; i < NUM_STAGES; i++) begin
            if (tally_nx[i] > best_val) begin
                best_val = tally_nx[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    assign credit_valid = last_cycle;
    assign credit_idx   = (len_m1 < LEN_W'(MIN_LEN_M1)) ? '0 : best_idx;
endmodule

// File: rtl/prof_counter_bank.sv
module prof_counter_bank #(
    parameter int NUM_STAGES = 8,
    parameter int CNT_W      = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            credit_valid,
    input  logic [$clog2(NUM_STAGES)-1:0]   credit_idx,
    output logic [NUM_STAGES-1:0][CNT_W-1:0] counts,
    output logic [CNT_W-1:0]                total
);
    logic wrap;

    assign wrap = credit_valid && (total == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
        end else if (clear || wrap) begin
            total <= '0;
        end else if (credit_valid) begin
            total <= total + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                counts[g] <= '0;
            end else if (clear || wrap) begin
                counts[g] <= '0;
            end else if (credit_valid && (credit_idx == g)) begin
                counts[g] <= counts[g] + 1'b1;
            end
        end
    end

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_valid && !clear && total == {CNT_W{1'b1}}) |=> (total == '0 && counts[0] == '0));
endmodule

// File: rtl/stage_profiler.sv
module stage_profiler
    import stage_profiler_pkg::*;
#(
    parameter int NUM_STAGES = 8,
    parameter int CNT_W      = 16,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN_M1 = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [CNT_W+LEN_W-1:0]  cfg_data,
    input  logic                    start,
    input  logic [NUM_STAGES-1:0]   stage_busy,
    input  logic                    rd_en,
    output logic                    rd_valid,
    output logic [2*CNT_W-1:0]      rd_data,
    output logic                    busy
);
    localparam int IDX_W     = $clog2(NUM_STAGES);
    localparam int NUM_WORDS = NUM_STAGES / 2;
    localparam int PTR_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    prof_state_e state_q, state_nx;

    logic [CNT_W-1:0]                 count_q;
    logic [LEN_W-1:0]                 len_q;
    logic                             unbounded;
    logic                             live_read;
    logic                             run_en;
    logic                             last_cycle;
    logic                             credit_valid;
    logic [IDX_W-1:0]                 credit_idx;
    logic                             final_credit;
    logic [NUM_STAGES-1:0][CNT_W-1:0] counts;
    logic [CNT_W-1:0]                 total;
    logic [NUM_STAGES-1:0][CNT_W-1:0] snap_q;
    logic [PTR_W-1:0]                 ptr_q;
    logic [NUM_WORDS-1:0][2*CNT_W-1:0] snap_words;

    assign unbounded = (count_q == '0);
    assign live_read = (state_q == ST_RUN) && unbounded && rd_en && !start;
    assign run_en    = (state_q == ST_RUN) && !start && !live_read;
    assign final_credit = credit_valid && !unbounded &&
                          ({1'b0, total} + 1'b1 == {1'b0, count_q});

    // Configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            len_q   <= '0;
        end else if (cfg_wr) begin
            count_q <= cfg_data[CNT_W-1:0];
            len_q   <= cfg_data[CNT_W +: LEN_W];
        end
    end

    prof_interval_timer #(.LEN_W(LEN_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .run        (run_en),
        .len_m1     (len_q),
        .last_cycle (last_cycle)
    );

    prof_stage_select #(
        .NUM_STAGES (NUM_STAGES),
        .LEN_W      (LEN_W),
        .MIN_LEN_M1 (MIN_LEN_M1)
    ) select_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (start),
        .run          (run_en),
        .last_cycle   (last_cycle),
        .len_m1       (len_q),
        .stage_busy   (stage_busy),
        .credit_valid (credit_valid),
        .credit_idx   (credit_idx)
    );

    prof_counter_bank #(
        .NUM_STAGES (NUM_STAGES),
        .CNT_W      (CNT_W)
    ) bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (start),
        .credit_valid (credit_valid),
        .credit_idx   (credit_idx),
        .counts       (counts),
        .total        (total)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        if (start) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_nx = ST_IDLE;
                ST_RUN: begin
                    if (live_read)         state_nx = ST_DONE;
                    else if (final_credit) state_nx = ST_SNAP;
                end
                ST_SNAP: state_nx = ST_DONE;
                ST_DONE: state_nx = ST_DONE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign snap_words[w] = {snap_q[2*w+1], snap_q[2*w]};
    end

    // Outputs: snapshot store, read pointer, read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q   <= '0;
            ptr_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en && !start;
            if (start) begin
                ptr_q <= '0;
            end else if (live_read) begin
                snap_q  <= counts;
                rd_data <= {counts[1], counts[0]};
                ptr_q   <= PTR_W'(1);
            end else if (state_q == ST_SNAP) begin
                snap_q <= counts;
                ptr_q  <= '0;
            end else if (rd_en) begin
                rd_data <= snap_words[ptr_q];
                ptr_q   <= (ptr_q == PTR_W'(NUM_WORDS - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    assign busy = (state_q == ST_RUN);

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    p_quiet_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!credit_valid && !start) |=> $stable(total));

    p_short_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_valid && len_q < LEN_W'(MIN_LEN_M1)) |-> (credit_idx == '0));

    p_bounded_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !unbounded) |-> (total < count_q));

    p_unbounded_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && unbounded && rd_en && !start && !cfg_wr) |=> !busy);

    p_read_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !start) |=> rd_valid);
endmodule

// File: tb/stage_profiler_tb_top.sv
module stage_profiler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        start = 1'b0;
    logic [7:0]  stage_busy;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        busy;

    int checks = 0;
    int errors = 0;

    // Stimulus for the activity flags: constant or alternating between two values
    logic [7:0] busy_a = '0;
    logic [7:0] busy_b = '0;
    bit         alt_mode = 1'b0;
    bit         phase = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic [31:0] mask;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    stage_profiler dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_data   (cfg_data),
        .start      (start),
        .stage_busy (stage_busy),
        .rd_en      (rd_en),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .busy       (busy)
    );

    always @(negedge clk) phase <= ~phase;
    assign stage_busy = (alt_mode && phase) ? busy_b : busy_a;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: pop and compare each result word
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected word", rd_data, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(((rd_data ^ e.data) & e.mask) == 0, e.req, rd_data, e.data);
            end
        end
    end

    // Driver: push expectation then pulse rd_en
    task automatic read_word(input logic [31:0] expv, input logic [31:0] mask,
                             input string req);
        exp_t e;
        e.data = expv;
        e.mask = mask;
        e.req  = req;
        exp_q.push_back(e);
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic configure_and_start(input logic [15:0] cnt, input logic [15:0] lm1);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_data = {lm1, cnt};
        @(negedge clk);
        cfg_wr = 1'b0;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1 busy after start", {31'b0, busy}, 32'h1);
    endtask

    task automatic wait_done(input string req);
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        check(busy == 1'b0, req, {31'b0, busy}, 32'h0);
        repeat (2) @(negedge clk);
    endtask

    // Bounded run, then read words 0..3 plus a wrapped fifth read
    task automatic bounded(input logic [15:0] cnt, input logic [15:0] lm1,
                           input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input logic [31:0] w3,
                           input string req);
        configure_and_start(cnt, lm1);
        wait_done("R6 busy falls after N intervals");
        read_word(w0, 32'hFFFF_FFFF, {req, " word0"});
        read_word(w1, 32'hFFFF_FFFF, {req, " word1"});
        read_word(w2, 32'hFFFF_FFFF, {req, " word2"});
        read_word(w3, 32'hFFFF_FFFF, {req, " word3"});
        read_word(w0, 32'hFFFF_FFFF, "R9 fifth read returns word0");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 reset busy low", {31'b0, busy}, 32'h0);
        check(rd_valid == 1'b0, "R9 reset rd_valid low", {31'b0, rd_valid}, 32'h0);
        read_word(32'h0, 32'hFFFF_FFFF, "R9 idle read zero");

        // R4: tie between stage 2 and 5 goes to stage 2 (word1 low half)
        busy_a = 8'h24; alt_mode = 1'b0;
        bounded(16'd5, 16'd3, 32'h0, 32'h0000_0005, 32'h0, 32'h0, "R4 tie lowest");

        // R4: stage 3 busy every cycle beats stage 1 busy half the cycles (word1 high half)
        busy_a = 8'h0A; busy_b = 8'h08; alt_mode = 1'b1;
        bounded(16'd7, 16'd3, 32'h0, 32'h0007_0000, 32'h0, 32'h0, "R4 majority");

        // R4: alternating stage 1 and stage 7, two cycles each, tie to stage 1 (word0 high)
        busy_a = 8'h02; busy_b = 8'h80; alt_mode = 1'b1;
        bounded(16'd2, 16'd3, 32'h0002_0000, 32'h0, 32'h0, 32'h0, "R4 alternating tie");

        // R2/R3/R6: tie stage 0 and 6 with 6-cycle intervals, count 3
        busy_a = 8'h41; alt_mode = 1'b0;
        bounded(16'd3, 16'd5, 32'h0000_0003, 32'h0, 32'h0, 32'h0, "R3 R2 count and length");

        // R5: two-cycle interval credits stage 0 although stage 4 is busy
        busy_a = 8'h10;
        bounded(16'd6, 16'd1, 32'h0000_0006, 32'h0, 32'h0, 32'h0, "R5 short interval");

        // R5: three-cycle interval credits the real stage 4 (word2 low)
        bounded(16'd4, 16'd2, 32'h0, 32'h0, 32'h0000_0004, 32'h0, "R5 threshold length");

        // R7: unbounded run with stage 7 busy, stops on first read
        busy_a = 8'h80;
        configure_and_start(16'd0, 16'd3);
        repeat (40) @(negedge clk);
        check(busy == 1'b1, "R7 unbounded still running", {31'b0, busy}, 32'h1);
        read_word(32'h0, 32'hFFFF_FFFF, "R7 live word0");
        check(busy == 1'b0, "R7 busy falls on read", {31'b0, busy}, 32'h0);
        read_word(32'h0, 32'hFFFF_FFFF, "R7 word1");
        read_word(32'h0, 32'hFFFF_FFFF, "R7 word2");
        read_word(32'h0, 32'h0000_FFFF, "R7 word3 low");
        repeat (2) @(negedge clk);

        // R8: unbounded one-cycle intervals past 0xFFFF wrap to a small count
        busy_a = 8'h00;
        configure_and_start(16'd0, 16'd0);
        repeat (65540) @(negedge clk);
        read_word(32'h0, 32'hFFFF_FFC0, "R8 wrapped word0");
        read_word(32'h0, 32'hFFFF_FFFF, "R8 word1");
        read_word(32'h0, 32'hFFFF_FFFF, "R8 word2");
        read_word(32'h0, 32'hFFFF_FFFF, "R8 word3");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule